// File: doc/BRIEF.md
# CAN Transceiver Channel Mode and Timeout Controller

This block is the digital control core of one channel of a CAN physical-layer transceiver. It sits between the protocol controller's transmit bit, a standby select input, a sampled bus-dominant flag from the receive comparator and an undervoltage flag. It produces three outputs: the enable and dominant-drive signals for the bus output stage, and the receive data pin back to the controller.

With standby low, the channel runs in Normal mode. The transmit bit steers the driver, and the receive pin follows the bus. With standby high, the driver is off. A low-power path then reports bus dominance only after a glitch filter, so a falling receive pin serves as a wake request. Leaving Standby takes a fixed delay, which a renewed standby request cancels. Two watchdogs guard against stuck-dominant faults:

- A transmit input held low in Normal mode disables the driver until the input is seen high.
- A bus held dominant while not in Normal mode latches the receive pin recessive until the bus has stayed recessive for a qualifying interval.

Every time is a parameter in clock cycles. All three data inputs are first retimed by a two-flop synchronizer. The undervoltage flag acts on the outputs combinationally.

Top module: `can_phy_mode_ctrl`

## Requirements
- R1: After reset the channel is in Standby: drv_en_o=0, drv_dom_o=0 and, with the bus recessive, rxd_o=1.
- R2: In Normal mode drv_en_o=1 and drv_dom_o equals the inverse of txd_i, delayed by 2 clock edges. A rise of stby_i switches the channel to Standby, and drv_en_o falls on the 3rd edge. drv_dom_o=1 never occurs while drv_en_o=0.
- R3: In Normal mode rxd_o equals the inverse of bus_dom_i (1 = bus dominant), delayed by 2 clock edges.
- R4: Outside Normal mode, rxd_o falls only after WAKE_FLT_CYC consecutive synchronized dominant samples, so it falls on edge WAKE_FLT_CYC+2 after bus_dom_i rises. A dominant burst of WAKE_FLT_CYC-1 cycles leaves rxd_o at 1. rxd_o returns high on the 3rd edge after the bus goes recessive.
- R5: After stby_i falls, drv_en_o rises on edge NORM_DLY_CYC and not earlier. During that delay drv_en_o stays 0 and rxd_o keeps the filtered Standby behaviour of R4.
- R6: A rise of stby_i during the Standby-to-Normal delay returns the channel to Standby. A later fall restarts the full NORM_DLY_CYC delay.
- R7: In Normal mode, txd_i held low for STUCK_CYC synchronized samples clears drv_en_o on edge STUCK_CYC+2 and forces drv_dom_o=0. The first high sample of txd_i releases the driver on the 3rd edge after the rise.
- R8: A high interval on txd_i shorter than REC_CYC cycles only pauses the transmit watchdog: its trip is delayed by the length of the interval. A high interval of REC_CYC cycles or more restarts the watchdog from zero.
- R9: Outside Normal mode, bus_dom_i held high for STUCK_CYC synchronized samples forces rxd_o=1 on edge STUCK_CYC+2. The latch holds through recessive intervals shorter than REC_CYC cycles. It clears after REC_CYC consecutive recessive samples, after which the wake filter of R4 works again.
- R10: While uv_i=1, drv_en_o=0, drv_dom_o=0 and rxd_o=1 in the same cycle, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit bit from protocol controller, 0 = dominant |
| stby_i | input | 1 | Mode select, 1 = Standby, 0 = Normal |
| bus_dom_i | input | 1 | Sampled comparator result, 1 = bus dominant |
| uv_i | input | 1 | Supply undervoltage flag |
| drv_en_o | output | 1 | Enables the bus output stage |
| drv_dom_o | output | 1 | Requests a dominant level from the output stage |
| rxd_o | output | 1 | Receive data pin, 0 = dominant or wake request |

## Verification
The latency of each result is fixed:

| Result | Due on |
|---|---|
| Normal-mode data paths | 2nd edge after the input change |
| Switch to Standby | 3rd edge |
| Wake filter output | edge WAKE_FLT_CYC+2 |
| Either watchdog trip | edge STUCK_CYC+2 |
| Transmit release | 3rd edge |
| Bus latch release | after REC_CYC recessive samples |
| Return to Normal | edge NORM_DLY_CYC after the standby fall |
| Undervoltage forcing | same cycle |

Stimulus is applied at a falling clock edge, and each result is sampled at a falling edge reached by counting rising edges from that point. Every timed result is checked once on the edge before it is due, where the old value must still hold, and once on the edge where the new value must appear. Shortened bursts and glitches sit just below the filter and qualification lengths.

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;
    typedef enum logic [1:0] {
        MODE_STBY = 2'd0,
        MODE_WAKE = 2'd1,
        MODE_NORM = 2'd2
    } phy_mode_e;
endpackage

// File: rtl/can_phy_sync.sv
module can_phy_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/can_phy_wake_flt.sv
module can_phy_wake_flt #(
    parameter int FLT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dom_i,
    output logic flt_o
);
    localparam int CW = $clog2(FLT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FLT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dom_i) begin
            if (st_q.cnt != LAST) st_d.cnt = st_q.cnt + CW'(1);
            st_d.flt = (st_q.cnt == LAST);
        end else begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_o = st_q.flt;

    // R4
    flt_needs_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flt) |-> $past(dom_i));
    // R4
    flt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_i |=> !st_q.flt);
endmodule

// File: rtl/can_phy_stuck_tmr.sv
module can_phy_stuck_tmr #(
    parameter int STUCK_CYC = 50000,
    parameter int REC_CYC   = 4,
    parameter bit QUICK_REL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic mon_i,
    output logic stuck_o
);
    localparam int DW = $clog2(STUCK_CYC + 1);
    localparam int RW = $clog2(REC_CYC + 1);
    localparam logic [DW-1:0] D_LAST = DW'(STUCK_CYC - 1);
    localparam logic [RW-1:0] R_LAST = RW'(REC_CYC - 1);

    typedef struct packed {
        logic [DW-1:0] dcnt;
        logic [RW-1:0] rcnt;
        logic          stuck;
    } tmr_t;

    tmr_t st_d, st_q;
    logic rel_now;

    generate
        if (QUICK_REL) begin : g_quick
            assign rel_now = st_q.stuck;
        end else begin : g_slow
            assign rel_now = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (mon_i) begin
            st_d.rcnt = '0;
            if (st_q.dcnt != D_LAST) st_d.dcnt = st_q.dcnt + DW'(1);
            else                     st_d.stuck = 1'b1;
        end else begin
            if (st_q.rcnt != R_LAST) st_d.rcnt = st_q.rcnt + RW'(1);
            if (rel_now || st_q.rcnt == R_LAST) begin
                st_d.dcnt  = '0;
                st_d.stuck = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stuck_o = st_q.stuck;

    // R7 R9
    stuck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stuck) |-> $past(en_i && mon_i));
    // R7 R9
    stuck_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.stuck);
endmodule

// File: rtl/can_phy_mode_ctrl.sv
module can_phy_mode_ctrl
    import can_phy_pkg::*;
#(
    parameter int WAKE_FLT_CYC = 40,
    parameter int NORM_DLY_CYC = 1000,
    parameter int STUCK_CYC    = 50000,
    parameter int REC_CYC      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic stby_i,
    input  logic bus_dom_i,
    input  logic uv_i,
    output logic drv_en_o,
    output logic drv_dom_o,
    output logic rxd_o
);
    localparam int NW   = $clog2(NORM_DLY_CYC);
    localparam int NLIM = NORM_DLY_CYC - 3;

    typedef struct packed {
        phy_mode_e     mode;
        logic [NW-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;
    logic [2:0] in_s;
    logic tx_s, stby_s, dom_s;
    logic wake_flt, tx_stuck, bus_stuck, is_norm;

    can_phy_sync #(.WIDTH(3), .RST_VAL(3'b011)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({bus_dom_i, stby_i, txd_i}), .q_o(in_s)
    );
    assign tx_s   = in_s[0];
    assign stby_s = in_s[1];
    assign dom_s  = in_s[2];

    can_phy_wake_flt #(.FLT_CYC(WAKE_FLT_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .dom_i(dom_s), .flt_o(wake_flt)
    );

    can_phy_stuck_tmr #(.STUCK_CYC(STUCK_CYC), .REC_CYC(REC_CYC), .QUICK_REL(1'b1)) u_tx_tmr (
        .clk(clk), .rst_n(rst_n), .en_i(is_norm), .mon_i(!tx_s), .stuck_o(tx_stuck)
    );

    can_phy_stuck_tmr #(.STUCK_CYC(STUCK_CYC), .REC_CYC(REC_CYC), .QUICK_REL(1'b0)) u_bus_tmr (
        .clk(clk), .rst_n(rst_n), .en_i(!is_norm), .mon_i(dom_s), .stuck_o(bus_stuck)
    );

    assign is_norm = (st_q.mode == MODE_NORM);

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            MODE_STBY: begin
                st_d.cnt = '0;
                if (!stby_s) st_d.mode = MODE_WAKE;
            end
            MODE_WAKE: begin
                if (stby_s) begin
                    st_d.mode = MODE_STBY;
                    st_d.cnt  = '0;
                end else if (st_q.cnt == NW'(NLIM - 1)) begin
                    st_d.mode = MODE_NORM;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + NW'(1);
                end
            end
            MODE_NORM: begin
                if (stby_s) st_d.mode = MODE_STBY;
            end
            default: st_d = '{mode: MODE_STBY, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_STBY, cnt: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        drv_en_o  = is_norm && !uv_i && !tx_stuck;
        drv_dom_o = drv_en_o && !tx_s;
        if (uv_i)         rxd_o = 1'b1;
        else if (is_norm) rxd_o = !dom_s;
        else              rxd_o = !(wake_flt && !bus_stuck);
    end

    // R2
    dom_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom_o |-> drv_en_o);
    // R10
    uv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> (!drv_en_o && !drv_dom_o && rxd_o));
    // R5
    stby_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_NORM) |-> !drv_en_o);
    // R5
    norm_via_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_NORM && $past(st_q.mode) != MODE_NORM) |-> $past(st_q.mode) == MODE_WAKE);
endmodule

// File: tb/can_phy_mode_ctrl_bench.sv
module can_phy_mode_ctrl_bench;
    localparam int W   = 6;
    localparam int N   = 20;
    localparam int S   = 40;
    localparam int REC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, stby = 1'b1, dom = 1'b0, uv = 1'b0;
    logic drv_en, drv_dom, rxd;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    can_phy_mode_ctrl #(.WAKE_FLT_CYC(W), .NORM_DLY_CYC(N), .STUCK_CYC(S), .REC_CYC(REC)) u_can_phy_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .stby_i(stby), .bus_dom_i(dom), .uv_i(uv),
        .drv_en_o(drv_en), .drv_dom_o(drv_dom), .rxd_o(rxd)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; txd = 1'b1; stby = 1'b1; dom = 1'b0; uv = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1", "drv_en", drv_en, 1'b0);
        chk("R1", "drv_dom", drv_dom, 1'b0);
        chk("R1", "rxd", rxd, 1'b1);
        tick(5);
    endtask

    task automatic t_wake_filter;
        logic seen_low;
        seen_low = 1'b0;
        dom = 1'b1; tick(W - 1); dom = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (rxd !== 1'b1) seen_low = 1'b1;
        end
        chk("R4", "short burst rxd low seen", seen_low, 1'b0);
        dom = 1'b1;
        tick(W + 1); chk("R4", "rxd before filter", rxd, 1'b1);
        tick(1);     chk("R4", "rxd after filter", rxd, 1'b0);
        dom = 1'b0;
        tick(2); chk("R4", "rxd hold", rxd, 1'b0);
        tick(1); chk("R4", "rxd release", rxd, 1'b1);
        tick(5);
    endtask

    task automatic t_bus_stuck;
        dom = 1'b1;
        tick(S + 1); chk("R9", "rxd before trip", rxd, 1'b0);
        tick(1);     chk("R9", "rxd forced", rxd, 1'b1);
        dom = 1'b0; tick(2); dom = 1'b1;
        tick(W + 5); chk("R9", "latch holds over short recessive", rxd, 1'b1);
        dom = 1'b0; tick(REC + 1); dom = 1'b1;
        tick(W + 1); chk("R9", "rearmed before filter", rxd, 1'b1);
        tick(1);     chk("R9", "rearmed wake", rxd, 1'b0);
        dom = 1'b0;
        tick(6);
    endtask

    task automatic t_wake_cancel;
        stby = 1'b0;
        tick(10); chk("R5", "drv_en during delay", drv_en, 1'b0);
        stby = 1'b1; tick(5);
        stby = 1'b0;
        tick(N - 1); chk("R6", "drv_en before restart done", drv_en, 1'b0);
        chk("R6", "rxd before restart done", rxd, 1'b1);
        tick(1);     chk("R6", "drv_en after full delay", drv_en, 1'b1);
        chk("R6", "drv_dom recessive", drv_dom, 1'b0);
        tick(3);
    endtask

    task automatic t_normal_io;
        txd = 1'b0;
        tick(1); chk("R2", "drv_dom edge1", drv_dom, 1'b0);
        tick(1); chk("R2", "drv_dom edge2", drv_dom, 1'b1);
        chk("R2", "drv_en", drv_en, 1'b1);
        txd = 1'b1;
        tick(1); chk("R2", "drv_dom hold", drv_dom, 1'b1);
        tick(1); chk("R2", "drv_dom release", drv_dom, 1'b0);
        dom = 1'b1;
        tick(1); chk("R3", "rxd edge1", rxd, 1'b1);
        tick(1); chk("R3", "rxd edge2", rxd, 1'b0);
        dom = 1'b0;
        tick(1); chk("R3", "rxd hold", rxd, 1'b0);
        tick(1); chk("R3", "rxd back", rxd, 1'b1);
        tick(3);
    endtask

    task automatic t_tx_stuck;
        txd = 1'b0;
        tick(S + 1); chk("R7", "drv_en before trip", drv_en, 1'b1);
        tick(1);     chk("R7", "drv_en tripped", drv_en, 1'b0);
        chk("R7", "drv_dom tripped", drv_dom, 1'b0);
        txd = 1'b1;
        tick(2); chk("R7", "drv_en before release", drv_en, 1'b0);
        tick(1); chk("R7", "drv_en released", drv_en, 1'b1);
        chk("R7", "drv_dom released", drv_dom, 1'b0);
        tick(5);
    endtask

    task automatic t_tx_glitch;
        txd = 1'b0; tick(10);
        txd = 1'b1; tick(2);
        txd = 1'b0;
        tick(S - 9); chk("R8", "short high pauses only", drv_en, 1'b1);
        tick(1);     chk("R8", "trip delayed by pause", drv_en, 1'b0);
        txd = 1'b1; tick(3);
        chk("R8", "released", drv_en, 1'b1);
        tick(3);
        txd = 1'b0; tick(10);
        txd = 1'b1; tick(REC);
        txd = 1'b0;
        tick(S + 1); chk("R8", "long high restarts timer", drv_en, 1'b1);
        tick(1);     chk("R8", "trip after restart", drv_en, 1'b0);
        txd = 1'b1; tick(5);
    endtask

    task automatic t_uv_normal;
        uv = 1'b1; #1;
        chk("R10", "drv_en under uv", drv_en, 1'b0);
        chk("R10", "rxd under uv", rxd, 1'b1);
        txd = 1'b0; dom = 1'b1;
        tick(3);
        chk("R10", "drv_dom under uv", drv_dom, 1'b0);
        chk("R10", "rxd under uv with bus dominant", rxd, 1'b1);
        uv = 1'b0; #1;
        chk("R10", "drv_dom after uv", drv_dom, 1'b1);
        chk("R10", "rxd after uv", rxd, 1'b0);
        txd = 1'b1; dom = 1'b0;
        tick(4);
    endtask

    task automatic t_to_standby;
        stby = 1'b1;
        tick(2); chk("R2", "drv_en before standby", drv_en, 1'b1);
        tick(1); chk("R2", "drv_en in standby", drv_en, 1'b0);
        dom = 1'b1;
        tick(W + 3); chk("R4", "standby wake", rxd, 1'b0);
        uv = 1'b1; #1;
        chk("R10", "standby rxd under uv", rxd, 1'b1);
        uv = 1'b0; dom = 1'b0;
        tick(6);
    endtask

    task automatic t_normal_entry;
        stby = 1'b0; dom = 1'b1;
        tick(W + 2); chk("R5", "filtered rxd during delay", rxd, 1'b0);
        chk("R5", "drv_en during delay", drv_en, 1'b0);
        dom = 1'b0;
        tick(N - 1 - (W + 2));
        chk("R5", "drv_en one edge early", drv_en, 1'b0);
        chk("R5", "rxd during delay", rxd, 1'b1);
        tick(1); chk("R5", "drv_en on time", drv_en, 1'b1);
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wake_filter();
        t_bus_stuck();
        t_wake_cancel();
        t_normal_io();
        t_tx_stuck();
        t_tx_glitch();
        t_uv_normal();
        t_to_standby();
        t_normal_entry();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule